// File: doc/BRIEF.md
# Multi-Zone Sensor Scan Controller

This controller runs one scan transaction on a shared 8-bit bus. The bus is wired to eight remote sensor groups and to a single latched lamp register. A start pulse supplies a zone number. The block then drives that number onto a 3-bit select, keeps the mode line low so an external 3-to-8 decoder enables that zone's buffer, and waits a settle time that is loaded per transaction. After the wait it samples the sensor byte.

Next it turns the bus around and builds an active-low lamp pattern. A zone with no active sensor gives all lamps off. A zone with any active sensor lights only the lamp whose index is the zone number. The block writes this pattern into the lamp register. To do so it raises the mode line, drives the bus, and pulses select bit 0 low and back high; the lamp register loads on the rising edge. A one-cycle done pulse ends the transaction.

Top module: `zone_scan_ctrl`

## Requirements
- R1: After reset, mode is 0, bus_oe is 0, done is 0, sel is 0 and sample is 0.
- R2: A start seen in idle latches zone. During the settle phase sel equals that zone, mode is 0 and bus_oe is 0.
- R3: Let S be settle_cycles at the start edge. The byte stored in sample is bus_in as it stands in the S-th cycle after the start edge, where cycle 0 is the cycle that begins at that edge.
- R4: If the sampled byte is 0x00, the lamp pattern on bus_out is 0xFF (every lamp off; a lamp is lit by a 0).
- R5: If the sampled byte is non-zero, the lamp pattern is 0xFF with only bit N cleared, where N is the zone number (an active sensor reads as 1).
- R6: bus_oe is 1 only while mode is 1. Before bus_oe rises there is one cycle with mode 1 and bus_oe 0, in cycle S+1.
- R7: While bus_oe is 1, sel is 3'b111 in cycle S+2, 3'b110 in cycle S+3 and 3'b111 in cycle S+4. The rising edge of sel[0] at the start of cycle S+4 loads the lamp register.
- R8: done is 1 for exactly one cycle, cycle S+5, with bus_oe 0. The block is idle again in cycle S+6, with mode 0 and done 0.
- R9: A start that arrives while a transaction is running is ignored. sel keeps the original zone.
- R10: sample holds the captured byte from cycle S+1 until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan transaction (acted on only in idle) |
| zone | input | 3 | Zone number to scan |
| settle_cycles | input | 16 | Settle wait, loaded at start |
| bus_in | input | 8 | Value read from the shared bus |
| sel | output | 3 | Decoder address; bit 0 is the lamp clock in lamp mode |
| mode | output | 1 | 0 = decoder read path, 1 = lamp register path |
| bus_out | output | 8 | Lamp pattern driven onto the bus |
| bus_oe | output | 1 | Bus output enable |
| sample | output | 8 | Last sampled sensor byte |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Let E be the clock edge at which start is taken. The sensor byte is taken from cycle S after E. The turnaround cycle is S+1, the pattern is on the bus from S+2, the lamp clock is low in S+3, done is in S+5 and the block is idle in S+6. The bench counts negative clock edges from E and compares every output in each of those cycles. In every settle cycle except cycle S it drives a decoy bus value whose pattern would differ. A sample taken one cycle early or late therefore shows up in sample, bus_out and the modelled lamp register.

// File: rtl/zscan_pkg.sv
package zscan_pkg;
    typedef enum logic [2:0] {
        ZS_IDLE,
        ZS_SETTLE,
        ZS_TURN,
        ZS_DRIVE,
        ZS_STROBE,
        ZS_RELEASE,
        ZS_DONE
    } zs_state_e;
endpackage

// File: rtl/zscan_settle_timer.sv
module zscan_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3: the wait shrinks by exactly one per running cycle
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/zscan_lamp_encode.sv
module zscan_lamp_encode #(
    parameter int SEL_W = 3,
    localparam int LANES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] zone,
    input  logic [LANES-1:0] sense,
    output logic [LANES-1:0] pattern
);
    logic any_active;
    assign any_active = |sense;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pattern[i] = !(any_active && (zone == SEL_W'(i)));
    end
endmodule

// File: rtl/zone_scan_ctrl.sv
module zone_scan_ctrl
    import zscan_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 16,
    localparam int LANES = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] zone,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [LANES-1:0] bus_in,
    output logic [SEL_W-1:0] sel,
    output logic             mode,
    output logic [LANES-1:0] bus_out,
    output logic             bus_oe,
    output logic [LANES-1:0] sample,
    output logic             done
);
    typedef struct packed {
        zs_state_e        state;
        logic [SEL_W-1:0] zone;
        logic [LANES-1:0] sample;
        logic [LANES-1:0] pattern;
    } zs_regs_t;

    zs_regs_t         r_d, r_q;
    logic             tmr_load, tmr_run, tmr_expired;
    logic [LANES-1:0] enc_pattern;

    zscan_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_cycles),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    zscan_lamp_encode #(.SEL_W(SEL_W)) u_encode (
        .zone    (r_q.zone),
        .sense   (bus_in),
        .pattern (enc_pattern)
    );

    assign tmr_load = (r_q.state == ZS_IDLE) && start;
    assign tmr_run  = (r_q.state == ZS_SETTLE);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ZS_IDLE: if (start) begin
                r_d.zone  = zone;
                r_d.state = ZS_SETTLE;
            end
            ZS_SETTLE: if (tmr_expired) begin
                r_d.sample  = bus_in;
                r_d.pattern = enc_pattern;
                r_d.state   = ZS_TURN;
            end
            ZS_TURN:    r_d.state = ZS_DRIVE;
            ZS_DRIVE:   r_d.state = ZS_STROBE;
            ZS_STROBE:  r_d.state = ZS_RELEASE;
            ZS_RELEASE: r_d.state = ZS_DONE;
            ZS_DONE:    r_d.state = ZS_IDLE;
            default:    r_d.state = ZS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ZS_IDLE;
            r_q.zone    <= '0;
            r_q.sample  <= '0;
            r_q.pattern <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mode   = r_q.state inside {ZS_TURN, ZS_DRIVE, ZS_STROBE, ZS_RELEASE, ZS_DONE};
        bus_oe = r_q.state inside {ZS_DRIVE, ZS_STROBE, ZS_RELEASE};
        done   = (r_q.state == ZS_DONE);
        if (!mode)
            sel = r_q.zone;
        else if (r_q.state == ZS_STROBE)
            sel = {{(SEL_W-1){1'b1}}, 1'b0};
        else
            sel = '1;
    end

    assign bus_out = r_q.pattern;
    assign sample  = r_q.sample;

    // R6: the bus is driven only on the lamp path
    a_r6_drive_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> mode);
    // R6: one idle cycle in lamp mode before the driver turns on
    a_r6_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> ($past(mode) && !$past(bus_oe)));
    // R2: the zone address stays fixed through the settle wait
    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ZS_SETTLE && $past(r_q.state) == ZS_SETTLE) |-> $stable(sel));
    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: done follows a low-then-high lamp clock
    a_r7_clock_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(sel[0]) && !$past(sel[0], 2)));
    // R5: a driven pattern has at most one lamp lit
    a_r5_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ($countones(bus_out) >= LANES - 1));
endmodule

// File: tb/zone_scan_ctrl_bench.sv
module zone_scan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  zone = '0;
    logic [15:0] settle_cycles = '0;
    logic [7:0]  bus_in = 8'h5A;
    logic [2:0]  sel;
    logic        mode;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  sample;
    logic        done;
    logic [7:0]  lamp_q = 8'hFF;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    zone_scan_ctrl u_zone_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .zone(zone),
        .settle_cycles(settle_cycles), .bus_in(bus_in), .sel(sel),
        .mode(mode), .bus_out(bus_out), .bus_oe(bus_oe),
        .sample(sample), .done(done)
    );

    // external lamp register, clocked by select bit 0 on the lamp path
    always @(posedge sel[0]) if (mode) lamp_q <= bus_out;

    function automatic logic [7:0] exp_lamp(input logic [2:0] z, input logic [7:0] d);
        return (d == 8'h00) ? 8'hFF : ~(8'h01 << z);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] z, input int s, input logic [7:0] d, input bit poke);
        logic [7:0] decoy;
        logic [7:0] pat;
        decoy = (d == 8'h00) ? 8'hFF : 8'h00;
        pat   = exp_lamp(z, d);
        @(negedge clk);
        start = 1'b1; zone = z; settle_cycles = 16'(s); bus_in = decoy;
        @(posedge clk);
        for (int k = 0; k <= s + 6; k++) begin
            @(negedge clk);
            start = (poke && k == 1);
            if (poke && k == 1) zone = z ^ 3'd5;
            bus_in = (k == s) ? d : (k < s ? decoy : 8'h5A);
            if (k <= s) begin
                chk(sel == z, "R2 sel", 32'(sel), 32'(z));
                chk(!mode && !bus_oe && !done, "R2 read path", {mode, bus_oe, done}, 0);
                if (poke) chk(sel == z, "R9 start ignored", 32'(sel), 32'(z));
            end else if (k == s + 1) begin
                chk(mode && !bus_oe, "R6 turnaround", {mode, bus_oe}, 2);
                chk(sample == d, "R3 sample", sample, d);
            end else if (k == s + 2) begin
                chk(bus_oe && sel == 3'b111, "R7 drive", {bus_oe, sel}, {1'b1, 3'b111});
                if (d == 8'h00) chk(bus_out == 8'hFF, "R4 all off", bus_out, 8'hFF);
                else            chk(bus_out == pat, "R5 one lamp", bus_out, pat);
            end else if (k == s + 3) begin
                chk(bus_oe && sel == 3'b110, "R7 clock low", {bus_oe, sel}, {1'b1, 3'b110});
            end else if (k == s + 4) begin
                chk(bus_oe && sel == 3'b111, "R7 clock high", {bus_oe, sel}, {1'b1, 3'b111});
            end else if (k == s + 5) begin
                chk(done && !bus_oe, "R8 done", {done, bus_oe}, 2);
                chk(lamp_q == pat, "R7 lamp loaded", lamp_q, pat);
            end else begin
                chk(!done && !mode && !bus_oe, "R8 idle", {done, mode, bus_oe}, 0);
                chk(sample == d, "R10 sample held", sample, d);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!mode && !bus_oe && !done && sel == 0 && sample == 0, "R1 reset",
            {mode, bus_oe, done, sel, sample}, 0);
        rst_n = 1'b1;
        run(3'd0, 0, 8'h01, 1'b0);
        run(3'd7, 0, 8'h00, 1'b0);
        run(3'd7, 3, 8'h80, 1'b0);
        run(3'd2, 5, 8'hFF, 1'b1);
        run(3'd6, 2, 8'h00, 1'b1);
        for (int i = 0; i < 40; i++) begin
            logic [2:0] z;
            logic [7:0] d;
            int s;
            z = 3'($urandom_range(0, 7));
            s = int'($urandom_range(0, 9));
            d = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
            run(z, s, d, (s >= 2) && ($urandom_range(0, 1) == 1));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule